// File: doc/BRIEF.md
# BCD Alarm Field Comparator

This block is the alarm half of a calendar clock. The clock core supplies six live BCD time fields: seconds, minutes, hours, weekday, day of month and month. Six alarm bytes sit on a small register bus. Each byte holds a BCD target in its low seven bits and a compare-enable in its top bit. A field whose enable is clear takes no part in the comparison, so an alarm can fire on a partial time such as "every day at 12:30:00".

When every enabled field equals its live counterpart, the block sets a sticky alarm flag. The flag is set once per new match. It stays set until software writes a zero to its bit in the control byte. The alarm interrupt line is the flag gated by an interrupt-enable bit in the same byte. Counting time and comparing the year are left to other blocks.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the flag and the interrupt line are 0, and every alarm byte and the control byte read back as 0x00.
- R2: Alarm bytes sit at register indices 8 (seconds), 9 (minutes), 10 (hours), 11 (weekday), 12 (day) and 13 (month). Each reads back the full 8 bits last written. The control byte sits at index 14: bit 0 is the flag and bit 3 is the interrupt enable, and all its other bits read 0. Every other index reads 0x00.
- R3: A field takes part in the comparison when bit 7 of its alarm byte is 1. It then matches when the low 7 bits of the byte equal the 7-bit live value. Month uses the same 1 to 12 BCD code as the live month input, so 0x92 matches month 0x12.
- R4: A field whose bit 7 is 0 (for example, one written with 0x00) is ignored. A match on the enabled fields alone sets the flag.
- R5: While no alarm byte has bit 7 set, the flag is never set.
- R6: The flag reads 1 in the cycle after the clock edge at which all enabled fields first match, having been 0 before that edge.
- R7: Once set, the flag holds until a write to the control byte with bit 0 equal to 0. Writing 1 to bit 0 never sets the flag.
- R8: After a clear, a match that continues without a break does not set the flag again. The match must drop and return.
- R9: The interrupt line is 1 exactly when the flag and the interrupt-enable bit are both 1.
- R10: When a new match and a clearing control write land on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read index |
| rd_data | output | 8 | Combinational read data |
| live_sec | input | 7 | Live BCD seconds |
| live_min | input | 7 | Live BCD minutes |
| live_hour | input | 7 | Live BCD hours |
| live_wday | input | 7 | Live BCD weekday |
| live_day | input | 7 | Live BCD day of month |
| live_mon | input | 7 | Live BCD month, 1 to 12 |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The assertions check on every cycle that:
- the flag holds unless a clearing write arrives;
- a clearing write with no new match empties it;
- a rise of the flag always follows a full match;
- a match held from the previous cycle never re-sets it;
- no match exists with all fields disabled;
- the interrupt never fires without both the flag and the enable.

Only the bench scenarios show the register map and read-back values, and which field patterns count as a match. They also show that a dropped and restored match re-arms the alarm.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_WDAY = 3'd3,
      FLD_DAY  = 3'd4,
      FLD_MON  = 3'd5
   } fld_e;
   localparam int unsigned NUM_FIELDS = 6;
   localparam int unsigned FLAG_BIT   = 0;
   localparam int unsigned IE_BIT     = 3;
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-2:0] live,
   output logic [DATA_W-1:0] cfg,
   output logic              en,
   output logic              pass
);
   localparam int unsigned VAL_W = DATA_W - 1;

   logic [DATA_W-1:0] cfg_q;
   logic              same;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (wr_sel) cfg_q <= wr_data;
   end

   assign same = (cfg_q[VAL_W-1:0] == live);
   assign en   = cfg_q[DATA_W-1];
   assign pass = !en || same;
   assign cfg  = cfg_q;
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic ctrl_wr,
   input  logic wr_flag_bit,
   input  logic wr_ie_bit,
   output logic flag,
   output logic ie,
   output logic irq
);
   logic hit_q;
   logic flag_q;
   logic ie_q;
   logic rise;

   assign rise = hit && !hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         flag_q <= 1'b0;
         ie_q   <= 1'b0;
      end else begin
         hit_q <= hit;
         if (ctrl_wr) ie_q <= wr_ie_bit;
         if (rise)                         flag_q <= 1'b1;
         else if (ctrl_wr && !wr_flag_bit) flag_q <= 1'b0;
      end
   end

   assign flag = flag_q;
   assign ie   = ie_q;
   assign irq  = flag_q && ie_q;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ALARM_BASE = 8,
   parameter int unsigned CTRL_IDX   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-2:0] live_sec,
   input  logic [DATA_W-2:0] live_min,
   input  logic [DATA_W-2:0] live_hour,
   input  logic [DATA_W-2:0] live_wday,
   input  logic [DATA_W-2:0] live_day,
   input  logic [DATA_W-2:0] live_mon,
   output logic              alarm_flag,
   output logic              alarm_irq
);
   import rtc_alarm_pkg::*;

   localparam int unsigned NF    = NUM_FIELDS;
   localparam int unsigned NREGS = 1 << ADDR_W;

   if (DATA_W < 4) begin : g_bad_data
      $error("DATA_W must be at least 4");
   end
   if (ALARM_BASE + NF > NREGS || CTRL_IDX >= NREGS) begin : g_bad_map
      $error("register indices exceed the address space");
   end
   if (CTRL_IDX >= ALARM_BASE && CTRL_IDX < ALARM_BASE + NF) begin : g_overlap
      $error("control index overlaps the alarm bytes");
   end

   logic [DATA_W-2:0] live_arr [NF];
   logic [DATA_W-1:0] cfg_arr  [NF];
   logic [NF-1:0]     en_vec;
   logic [NF-1:0]     pass_vec;
   logic              any_en;
   logic              hit;
   logic              ctrl_wr;
   logic              ie;

   assign live_arr[FLD_SEC]  = live_sec;
   assign live_arr[FLD_MIN]  = live_min;
   assign live_arr[FLD_HOUR] = live_hour;
   assign live_arr[FLD_WDAY] = live_wday;
   assign live_arr[FLD_DAY]  = live_day;
   assign live_arr[FLD_MON]  = live_mon;

   for (genvar g = 0; g < NF; g++) begin : g_fld
      logic sel;
      assign sel = wr_en && (wr_addr == ADDR_W'(ALARM_BASE + g));
      rtc_alarm_field #(.DATA_W(DATA_W)) u_fld (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (sel),
         .wr_data (wr_data),
         .live    (live_arr[g]),
         .cfg     (cfg_arr[g]),
         .en      (en_vec[g]),
         .pass    (pass_vec[g])
      );
   end

   assign any_en  = |en_vec;
   assign hit     = any_en && (&pass_vec);
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));

   rtc_alarm_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .ctrl_wr     (ctrl_wr),
      .wr_flag_bit (wr_data[FLAG_BIT]),
      .wr_ie_bit   (wr_data[IE_BIT]),
      .flag        (alarm_flag),
      .ie          (ie),
      .irq         (alarm_irq)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(CTRL_IDX)) begin
         rd_data[FLAG_BIT] = alarm_flag;
         rd_data[IE_BIT]   = ie;
      end
      for (int i = 0; i < NF; i++) begin
         if (rd_addr == ADDR_W'(ALARM_BASE + i)) rd_data = cfg_arr[i];
      end
   end
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned CTRL_IDX = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_flag_bit,
   input logic              hit,
   input logic              any_en,
   input logic              ie,
   input logic              alarm_flag,
   input logic              alarm_irq
);
   logic clr_wr;
   assign clr_wr = wr_en && (wr_addr == ADDR_W'(CTRL_IDX)) && !wr_flag_bit;

   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_flag && !clr_wr |=> alarm_flag); // R7
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr && !hit |=> !alarm_flag); // R7
   AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(hit)); // R6
   AST_NO_FIELD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !any_en |-> !hit); // R5
   AST_HELD_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      hit && $past(hit) && !alarm_flag |=> !alarm_flag); // R8
   AST_NEW_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !$past(hit) |=> alarm_flag); // R10
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> alarm_flag); // R9
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |-> !alarm_irq); // R9
endmodule

bind rtc_alarm_match rtc_alarm_chk #(.ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_flag_bit (wr_data[0]),
   .hit         (hit),
   .any_en      (any_en),
   .ie          (ie),
   .alarm_flag  (alarm_flag),
   .alarm_irq   (alarm_irq)
);

// File: tb/sim_rtc_alarm_match.sv
`timescale 1ns/1ps
module sim_rtc_alarm_match;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [6:0] l_sec = '0, l_min = '0, l_hour = '0, l_wday = '0, l_day = '0, l_mon = '0;
   logic       alarm_flag, alarm_irq;
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   rtc_alarm_match u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .live_sec(l_sec), .live_min(l_min), .live_hour(l_hour),
      .live_wday(l_wday), .live_day(l_day), .live_mon(l_mon),
      .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   // sec, min, hour, wday, day, mon, expected flag
   localparam logic [48:0] VEC [8] = '{
      {8'h30, 8'h00, 8'h12, 8'h03, 8'h01, 8'h12, 1'b1},
      {8'h31, 8'h00, 8'h12, 8'h03, 8'h01, 8'h12, 1'b0},
      {8'h30, 8'h59, 8'h12, 8'h03, 8'h28, 8'h12, 1'b1},
      {8'h30, 8'h00, 8'h13, 8'h03, 8'h01, 8'h12, 1'b0},
      {8'h30, 8'h00, 8'h12, 8'h04, 8'h01, 8'h12, 1'b0},
      {8'h30, 8'h00, 8'h12, 8'h03, 8'h01, 8'h11, 1'b0},
      {8'h30, 8'h45, 8'h12, 8'h03, 8'h31, 8'h12, 1'b1},
      {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0}
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic put_time(input logic [48:0] v);
      @(negedge clk);
      l_sec = v[47:41]; l_min = v[39:33]; l_hour = v[31:25];
      l_wday = v[23:17]; l_day = v[15:9]; l_mon = v[7:1];
   endtask

   task automatic settle;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1 reset state
      check({7'd0, alarm_flag}, 8'h00, "R1 flag");
      check({7'd0, alarm_irq}, 8'h00, "R1 irq");
      for (int i = 8; i <= 14; i++) begin
         rd(4'(i), d);
         check(d, 8'h00, "R1 register");
      end

      // R2 map and read back
      wr(4'd10, 8'h5A); rd(4'd10, d); check(d, 8'h5A, "R2 hour byte");
      wr(4'd13, 8'h92); rd(4'd13, d); check(d, 8'h92, "R2 month byte");
      rd(4'd3, d);  check(d, 8'h00, "R2 unmapped low");
      wr(4'd15, 8'hFF); rd(4'd15, d); check(d, 8'h00, "R2 unmapped high");
      wr(4'd14, 8'hF8); rd(4'd14, d); check(d, 8'h08, "R2 control bits");
      wr(4'd10, 8'h00); wr(4'd13, 8'h00); wr(4'd14, 8'h00);

      // R5 all fields disabled
      put_time(VEC[0]); settle();
      check({7'd0, alarm_flag}, 8'h00, "R5 no field enabled");
      put_time(VEC[7]); settle();
      check({7'd0, alarm_flag}, 8'h00, "R5 still clear");

      // table: sec 30, hour 12, weekday 3, month 12 enabled; min and day disabled
      wr(4'd8, 8'hB0); wr(4'd9, 8'h00); wr(4'd10, 8'h92);
      wr(4'd11, 8'h83); wr(4'd12, 8'h00); wr(4'd13, 8'h92);
      for (int k = 0; k < 8; k++) begin
         put_time(VEC[7]);
         wr(4'd14, 8'h00);
         put_time(VEC[k]);
         settle();
         check({7'd0, alarm_flag}, {7'd0, VEC[k][0]}, "R3 R4 R6 table");
      end

      // R6 timing: flag still 0 before the edge that sees the match
      put_time(VEC[7]); wr(4'd14, 8'h00);
      put_time(VEC[0]);
      #1 check({7'd0, alarm_flag}, 8'h00, "R6 before edge");
      settle();
      check({7'd0, alarm_flag}, 8'h01, "R6 after edge");

      // R9 interrupt gating
      check({7'd0, alarm_irq}, 8'h00, "R9 irq off when disabled");
      wr(4'd14, 8'h09);
      check({7'd0, alarm_irq}, 8'h01, "R9 irq on");
      rd(4'd14, d); check(d, 8'h09, "R9 control read");
      // R7 write 1 to flag keeps it, ie off gates irq
      wr(4'd14, 8'h01);
      check({7'd0, alarm_flag}, 8'h01, "R7 write one keeps flag");
      check({7'd0, alarm_irq}, 8'h00, "R9 irq gated");
      // R8 clear while match persists
      wr(4'd14, 8'h00);
      check({7'd0, alarm_flag}, 8'h00, "R7 clear");
      repeat (3) settle();
      check({7'd0, alarm_flag}, 8'h00, "R8 held match no re-set");
      put_time(VEC[7]); settle();
      put_time(VEC[0]); settle();
      check({7'd0, alarm_flag}, 8'h01, "R8 re-armed");
      // R7 writing one while clear does not set
      put_time(VEC[7]); wr(4'd14, 8'h00);
      wr(4'd14, 8'h01);
      check({7'd0, alarm_flag}, 8'h00, "R7 write one no set");

      // R10 new match and clear on the same edge
      put_time(VEC[0]); settle();
      put_time(VEC[7]); settle();
      check({7'd0, alarm_flag}, 8'h01, "R10 setup");
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd14; wr_data = 8'h00;
      l_sec = 7'h30; l_hour = 7'h12; l_wday = 7'h03; l_mon = 7'h12;
      @(negedge clk);
      wr_en = 1'b0;
      check({7'd0, alarm_flag}, 8'h01, "R10 set wins");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule